// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is the serial target that lets a host read and change the configuration of a multi-rail supply supervisor over a standard I2C two-wire bus. It holds six configuration bytes and also exposes one live fault status byte. The SCL and SDA lines are oversampled on the system clock. The block pulls SDA low through an open-drain enable. Four address bits select the device type, and three more select the bus address. Two of those three come from board pins. The third comes from a stored configuration bit, so a host can move the device to a second address by writing it.

Writes are protected by two level inputs. A host sets the register pointer with one byte, sends exactly one data byte, and the value is stored only when a stop condition follows. A read with no new pointer returns the location just after the last one accessed. After a stored write, the block stays busy for a fixed interval and ignores its address during that time.

The bus side is a plain open-drain line pair. It has no valid/ready stream, so there is no back-pressure beyond the acknowledge bit. The configuration outputs are plain levels that change on one clock edge.

Top module: `cfg_serial_target`

## Requirements
- R1: After reset, all six configuration bytes read zero on `cfg_o` and `sda_oe_o` is low.
- R2: The target responds only to an address byte whose bits 7..4 are 1001, whose bits 3..1 equal {bit 0 of register 5, `addr_pin_i[1]`, `addr_pin_i[0]`}, and whose bit 0 is the read (1) or write (0) flag. A mismatched address gets no acknowledge and changes neither the registers nor the pointer.
- R3: Bits are sampled while SCL is high. The target drives SDA low for the acknowledge clock after each accepted byte. `sda_oe_o` changes only while SCL is low or when a start or stop condition occurs, and SDA is released after a stop.
- R4: A write is the address byte, then a pointer byte (bits 3..0 give register 0..15), then one data byte. The data is stored only when a stop follows. If a repeated start comes instead of the stop, the data is discarded.
- R5: Data is stored only if `manual_rst_n` is low and `power_req_n` is high when the stop is seen. Otherwise the byte is still acknowledged, but the registers stay unchanged and the pointer keeps the pointer byte value.
- R6: Any byte after the first data byte of a write is not acknowledged and does not reach any register.
- R7: The pointer advances by one (modulo 16) after every read byte and after every stored write. A read that sends no pointer byte returns the register at the current pointer.
- R8: Address 6 returns the live `fault_i` value. Addresses 7 to 15 read as zero. Writes to addresses 6 to 15 are discarded.
- R9: For BUSY_CYCLES clocks after a stored write, the target does not acknowledge any address byte. After that interval it responds again.
- R10: A random read is a write address byte, a pointer byte, a repeated start, a read address byte, then one data byte ended by a master no-acknowledge and a stop. It returns the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_pin_i | input | 2 | Low two bus address bits from board pins |
| manual_rst_n | input | 1 | Manual reset level; must be low for writes to store |
| power_req_n | input | 1 | Active-low power-on request; must be high for writes to store |
| fault_i | input | 8 | Live fault status byte read at address 6 |
| cfg_o | output | NUM_CFG*8 | Configuration bytes, register n at bits 8n+7..8n |

## Verification
The assertions assume that the SCL low phase lasts longer than the input synchronizer delay plus one clock. This lets a change of the enable after a falling edge show up while SCL is still low. They also assume the gate levels are steady around a stop. The bench master holds each bus quarter-phase for six clocks and changes SDA only in the middle of the SCL low phase, except for the start and stop edges. It changes the gate inputs and pins only between transactions. The random mix of writes, pointer-only writes, random reads and current-address reads includes writes to register 5, so the bus address moves during the run. The bench model tracks that change.

// File: rtl/cfgst_pkg.sv
package cfgst_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1001;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_ACK,
    ST_RD,
    ST_RDACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/cfgst_line_sampler.sv
module cfgst_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s     = scl_pipe[SYNC_STAGES-1];
  assign sda_s     = sda_pipe[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/cfgst_byte_engine.sv
module cfgst_byte_engine
  import cfgst_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_s,
  input  logic [2:0]       bus_addr,
  input  logic             busy,
  input  logic [7:0]       rd_byte,
  output logic             sda_oe,
  output logic             ptr_wr,
  output logic [PTR_W-1:0] ptr_val,
  output logic             rd_take,
  output logic             commit,
  output logic [7:0]       wr_data
);
  tgt_state_e state, ack_next;
  logic [2:0] bitcnt;
  logic [6:0] shreg, txsh;
  logic [7:0] rx_byte;
  logic       ack_phase, have_data, byte_end, addr_hit;

  assign rx_byte  = {shreg, sda_s};
  assign byte_end = scl_rise && (bitcnt == 3'd7);
  assign addr_hit = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == bus_addr) && !busy;
  assign ptr_wr   = (state == ST_PTR) && byte_end;
  assign ptr_val  = rx_byte[PTR_W-1:0];
  assign rd_take  = (state == ST_ACK) && scl_fall && ack_phase && (ack_next == ST_RD);
  assign commit   = stop_det && have_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ack_phase <= 1'b0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
      wr_data   <= '0;
    end else if (start_det) begin
      state     <= ST_ADDR;
      bitcnt    <= '0;
      ack_phase <= 1'b0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_det) begin
      state     <= ST_IDLE;
      ack_phase <= 1'b0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_DATA: begin
          if (scl_rise) begin
            shreg  <= rx_byte[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (byte_end) begin
              if (state == ST_ADDR) begin
                if (addr_hit) begin
                  state    <= ST_ACK;
                  ack_next <= rx_byte[0] ? ST_RD : ST_PTR;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_PTR) begin
                state    <= ST_ACK;
                ack_next <= ST_DATA;
              end else begin
                state     <= ST_ACK;
                ack_next  <= ST_WAIT;
                wr_data   <= rx_byte;
                have_data <= 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ack_phase) begin
              ack_phase <= 1'b1;
              sda_oe    <= 1'b1;
            end else begin
              ack_phase <= 1'b0;
              bitcnt    <= '0;
              state     <= ack_next;
              if (ack_next == ST_RD) begin
                txsh   <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              state  <= ST_RDACK;
            end else begin
              sda_oe <= ~txsh[6];
              txsh   <= {txsh[5:0], 1'b0};
              bitcnt <= bitcnt + 3'd1;
            end
          end
        end
        ST_RDACK: begin
          if (scl_rise) state <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfgst_reg_bank.sv
module cfgst_reg_bank #(
  parameter int NUM_CFG     = 6,
  parameter int PTR_W       = 4,
  parameter int BUSY_CYCLES = 400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ptr_wr,
  input  logic [PTR_W-1:0]     ptr_val,
  input  logic                 rd_take,
  input  logic                 commit,
  input  logic [7:0]           wr_data,
  input  logic                 manual_rst_n,
  input  logic                 power_req_n,
  input  logic [7:0]           fault_i,
  output logic [7:0]           rd_byte,
  output logic                 busy,
  output logic                 a2_bit,
  output logic [NUM_CFG*8-1:0] cfg_flat
);
  localparam int IDX_W = $clog2(NUM_CFG);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [PTR_W-1:0] FAULT_PTR = PTR_W'(NUM_CFG);

  logic [NUM_CFG-1:0][7:0] regs;
  logic [NUM_CFG-1:0]      wen;
  logic [PTR_W-1:0]        ptr;
  logic [CNT_W-1:0]        busy_cnt;
  logic                    commit_ok, ptr_in_cfg;

  assign ptr_in_cfg = ptr < FAULT_PTR;
  assign commit_ok  = commit && !manual_rst_n && power_req_n && ptr_in_cfg;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    assign wen[g]              = commit_ok && (ptr == PTR_W'(g));
    assign cfg_flat[g*8 +: 8]  = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (wen[i]) regs[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ptr_wr) begin
      ptr <= ptr_val;
    end else if (commit_ok || rd_take) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (commit_ok) begin
      busy_cnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assign busy   = busy_cnt != '0;
  assign a2_bit = regs[NUM_CFG-1][0];

  always_comb begin
    if (ptr_in_cfg)             rd_byte = regs[ptr[IDX_W-1:0]];
    else if (ptr == FAULT_PTR)  rd_byte = fault_i;
    else                        rd_byte = '0;
  end
endmodule

// File: rtl/cfg_serial_target.sv
module cfg_serial_target #(
  parameter int NUM_CFG     = 6,
  parameter int PTR_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int BUSY_CYCLES = 400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic [1:0]           addr_pin_i,
  input  logic                 manual_rst_n,
  input  logic                 power_req_n,
  input  logic [7:0]           fault_i,
  output logic [NUM_CFG*8-1:0] cfg_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_wr, rd_take, commit, busy, a2_bit;
  logic [PTR_W-1:0] ptr_val;
  logic [7:0] wr_data, rd_byte;

  cfgst_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  cfgst_byte_engine #(.PTR_W(PTR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .bus_addr({a2_bit, addr_pin_i}), .busy(busy), .rd_byte(rd_byte),
    .sda_oe(sda_oe_o), .ptr_wr(ptr_wr), .ptr_val(ptr_val),
    .rd_take(rd_take), .commit(commit), .wr_data(wr_data)
  );

  cfgst_reg_bank #(.NUM_CFG(NUM_CFG), .PTR_W(PTR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_bank (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_val(ptr_val),
    .rd_take(rd_take), .commit(commit), .wr_data(wr_data),
    .manual_rst_n(manual_rst_n), .power_req_n(power_req_n), .fault_i(fault_i),
    .rd_byte(rd_byte), .busy(busy), .a2_bit(a2_bit), .cfg_flat(cfg_o)
  );
endmodule

// File: rtl/cfgst_checker.sv
module cfgst_checker #(
  parameter int CFG_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_oe_o,
  input logic             stop_det,
  input logic             busy,
  input logic             manual_rst_n,
  input logic             power_req_n,
  input logic [CFG_W-1:0] cfg_o
);
  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);  // R3

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);  // R3

  AST_CFG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(!manual_rst_n && power_req_n));  // R5

  AST_CFG_STARTS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> busy);  // R9

  AST_SILENT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe_o);  // R9
endmodule

bind cfg_serial_target cfgst_checker #(.CFG_W(NUM_CFG*8)) u_cfgst_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .stop_det(stop_det), .busy(busy), .manual_rst_n(manual_rst_n),
  .power_req_n(power_req_n), .cfg_o(cfg_o)
);

// File: tb/cfg_serial_target_tb_top.sv
module cfg_serial_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int BUSY       = 400;
  localparam int NCFG       = 6;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_low = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [1:0] pins = 2'b10;
  logic mr_n = 1'b0;
  logic pwr_n = 1'b1;
  logic [7:0] fault = 8'h00;
  logic [NCFG*8-1:0] cfg;

  int checks = 0;
  int failures = 0;
  logic [7:0] mdl [NCFG];
  int mptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = !(m_sda_low || sda_oe);

  cfg_serial_target #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_pin_i(pins), .manual_rst_n(mr_n), .power_req_n(pwr_n),
    .fault_i(fault), .cfg_o(cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev(input bit rw);
    return {4'b1001, mdl[5][0], pins, rw};
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (a < NCFG) return mdl[a];
    if (a == NCFG) return fault;
    return 8'h00;
  endfunction

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    m_scl = 1'b0; qwait();
    m_sda_low = !b; qwait();
    m_scl = 1'b1; qwait(); qwait();
  endtask

  task automatic bus_start();
    m_scl = 1'b0; qwait();
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    m_sda_low = 1'b1; qwait();
  endtask

  task automatic bus_stop();
    m_scl = 1'b0; qwait();
    m_sda_low = 1'b1; qwait();
    m_scl = 1'b1; qwait();
    m_sda_low = 1'b0; qwait();
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_scl = 1'b0; qwait();
    m_sda_low = 1'b0; qwait();
    m_scl = 1'b1; qwait();
    ack = !sda_line; qwait();
  endtask

  task automatic rd_byte(output logic [7:0] d, input bit m_ack);
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_scl = 1'b0; qwait();
      m_sda_low = 1'b0; qwait();
      m_scl = 1'b1; qwait();
      d = {d[6:0], sda_line}; qwait();
    end
    send_bit(!m_ack);
  endtask

  task automatic wait_busy();
    repeat (BUSY + 20) @(negedge clk);
  endtask

  // full write; updates the model from the gate levels
  task automatic do_write(input string req, input int p, input logic [7:0] d);
    bit a0, a1, a2;
    bit ok;
    a1 = 1'b0; a2 = 1'b0;
    bus_start();
    wr_byte(dev(1'b0), a0);
    if (a0) wr_byte(8'(p), a1);
    if (a1) wr_byte(d, a2);
    bus_stop();
    chk({req, " write acks"}, {a0, a1, a2}, 3'b111);
    ok = !mr_n && pwr_n && (p < NCFG);
    if (ok) begin
      mdl[p] = d;
      mptr = (p + 1) % 16;
      wait_busy();
    end else begin
      mptr = p;
    end
    for (int i = 0; i < NCFG; i++) chk({req, " cfg"}, cfg[i*8 +: 8], mdl[i]);
  endtask

  task automatic do_ptr_only(input string req, input int p);
    bit a0, a1;
    a1 = 1'b0;
    bus_start();
    wr_byte(dev(1'b0), a0);
    if (a0) wr_byte(8'(p), a1);
    bus_stop();
    chk({req, " pointer acks"}, {a0, a1}, 2'b11);
    mptr = p;
  endtask

  task automatic do_read_at(input string req, input int p);
    bit a0, a1, a2;
    logic [7:0] d;
    a1 = 1'b0; a2 = 1'b0; d = 8'hxx;
    bus_start();
    wr_byte(dev(1'b0), a0);
    if (a0) wr_byte(8'(p), a1);
    bus_start();
    wr_byte(dev(1'b1), a2);
    if (a2) rd_byte(d, 1'b0);
    bus_stop();
    chk({req, " random read acks"}, {a0, a1, a2}, 3'b111);
    chk({req, " random read data"}, d, exp_rd(p));
    mptr = (p + 1) % 16;
  endtask

  task automatic do_read_cur(input string req);
    bit a0;
    logic [7:0] d;
    d = 8'hxx;
    bus_start();
    wr_byte(dev(1'b1), a0);
    if (a0) rd_byte(d, 1'b0);
    bus_stop();
    chk({req, " current read ack"}, a0, 1'b1);
    chk({req, " current read data"}, d, exp_rd(mptr));
    mptr = (mptr + 1) % 16;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit a, b;
    logic [7:0] d;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < NCFG; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state
    chk("R1 sda_oe", sda_oe, 1'b0);
    chk("R1 cfg", cfg, '0);

    // R3 R4 R10 R7: basic writes and reads
    do_write("R4", 0, 8'h11);
    do_write("R4", 1, 8'h22);
    do_write("R3", 2, 8'hA5);
    do_read_at("R10", 0);
    do_read_cur("R7");
    do_read_cur("R7");

    // R2: wrong type and wrong bus address
    bus_start(); wr_byte(8'hA0 | {pins, 1'b0}, a); bus_stop();
    chk("R2 wrong type nack", a, 1'b0);
    bus_start(); wr_byte({4'b1001, 1'b1, ~pins, 1'b0}, a); bus_stop();
    chk("R2 wrong bus addr nack", a, 1'b0);
    do_read_cur("R2 pointer untouched");

    // R5: gate closed two ways
    mr_n = 1'b1; do_write("R5 mr high", 4, 8'h77);
    mr_n = 1'b0; pwr_n = 1'b0; do_write("R5 power low", 3, 8'h66);
    pwr_n = 1'b1;
    do_read_cur("R5 pointer held");

    // R4: repeated start instead of stop discards data
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'd1, a); wr_byte(8'h99, a);
    bus_start(); wr_byte(dev(1'b1), b); rd_byte(d, 1'b0); bus_stop();
    chk("R4 repeated start data", d, 8'h22);
    chk("R4 repeated start cfg", cfg[15:8], 8'h22);
    mptr = 2;

    // R6: extra data byte not acknowledged
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'd2, a); wr_byte(8'h3C, a);
    wr_byte(8'hC3, b); bus_stop();
    chk("R6 first data ack", a, 1'b1);
    chk("R6 extra byte nack", b, 1'b0);
    mdl[2] = 8'h3C; mptr = 3;
    wait_busy();
    chk("R6 reg2", cfg[23:16], 8'h3C);
    chk("R6 reg3", cfg[31:24], 8'h00);

    // R8: fault register and unused space
    fault = 8'h5A;
    do_read_at("R8 fault", 6);
    do_read_at("R8 unused", 9);
    do_write("R8 write fault discarded", 6, 8'hFF);
    do_read_cur("R8 fault after write");
    do_read_at("R7 top", 15);
    do_read_cur("R7 wrap");

    // R9: busy after store
    do_ptr_only("R9", 0);
    bus_start(); wr_byte(dev(1'b0), a); wr_byte(8'd4, a); wr_byte(8'h44, a); bus_stop();
    mdl[4] = 8'h44; mptr = 5;
    bus_start(); wr_byte(dev(1'b1), a); bus_stop();
    chk("R9 nack while busy", a, 1'b0);
    wait_busy();
    do_read_cur("R9 ack after busy");

    // R2: stored address bit moves the device
    do_write("R2 set a2", 5, 8'h01);
    bus_start(); wr_byte({4'b1001, 1'b0, pins, 1'b1}, a); bus_stop();
    chk("R2 old address nack", a, 1'b0);
    do_read_at("R2 new address", 5);

    // mixed random traffic
    for (int it = 0; it < 60; it++) begin
      int op, p;
      op = $urandom % 4;
      p  = $urandom % 10;
      fault = 8'($urandom);
      mr_n  = ($urandom % 5) == 0;
      pwr_n = ($urandom % 5) != 0;
      case (op)
        0: do_write("R4 R5 rand", p, 8'($urandom));
        1: do_read_at("R10 rand", p);
        2: do_read_cur("R7 rand");
        default: do_ptr_only("R7 rand", p);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule